// File: doc/BRIEF.md
# Indexed Interrupt Routing Register Unit

This block holds the programmable state of a 24-input interrupt routing controller and exposes it through an index/data pair on a simple synchronous bus port. Software first writes a one-byte selector at bus offset 0x00. It then reads or writes a 32-bit data window at bus offset 0x10. Depending on the selector, the window reaches one of four things: an identification register, a fixed version word, an arbitration word that mirrors the identification value, or one 32-bit half of a 64-bit routing entry.

Each routing entry carries a vector, a delivery mode, a destination mode, a polarity, a trigger mode, a mask bit and a destination byte. Software owns all of these. Two further status bits, the remote-acknowledge flag and the delivery-pending flag, belong to hardware, and software writes to them have no effect. The trigger logic sees each entry's mask, trigger mode, polarity and remote-acknowledge flag as parallel vectors. It feeds back set and clear pulses for the remote-acknowledge flag and a pending level for each input.

The selector decoder sorts every selector into one access kind: identification, version, arbitration, an unused low slot, a valid entry half, or an index past the table. Each bus access is handled according to that kind.

Top module: `irq_route_regs`

## Requirements
- R1: A write of bus_wdata[7:0] at offset 0x00 sets the selector. A read at offset 0x00 returns that byte in bits 7:0 with zeros above, for any byte value.
- R2: With selector 0x01, a window read returns 0x00170011 whatever was written there before.
- R3: With selector 0x00, a window write keeps only bus_wdata[27:24]. A read returns that nibble in bits 27:24 with every other bit zero, so writing 0x1F3E5D7C reads back 0x0F000000.
- R4: With selector 0x02, a window read returns the same word as selector 0x00, and writes there are ignored.
- R5: Selectors 0x03 to 0x0F read 0. Selectors 0x40 and above (entry index 24 or more) read 0xFFFFFFFF. Window writes to either range change nothing.
- R6: Entry n is reached at selector 0x10+2n for the low half and 0x11+2n for the high half. The low half has this layout: bits 7:0 vector, 10:8 delivery mode, 11 destination mode, 12 delivery pending, 13 polarity, 14 remote acknowledge, 15 trigger mode (1 = level), 16 mask. Low bits 31:17 and high bits 23:0 read 0, and high bits 31:24 hold the destination.
- R7: Software writes to bits 12 and 14 of a low half are ignored. Bit 12 shows the hw_pend level sampled at the last clock edge. Bit 14 is set by an hw_irr_set pulse and cleared by an hw_irr_clr pulse, with set winning if both arrive together.
- R8: A low-half write whose bit 15 is 0 clears that entry's remote-acknowledge flag, and this takes priority over a hardware set in the same cycle.
- R9: After reset, every entry reads mask = 1 with all other fields 0, and the selector, identification value and bus_rdata are 0.
- R10: Writes at bus offsets other than 0x00 and 0x10 are ignored, and reads there return 0.
- R11: bus_rdata is updated at the clock edge that samples bus_rd and holds its value in every cycle without a read.
- R12: The ent_mask, ent_level, ent_polarity and ent_irr outputs carry bit n from entry n's stored mask, trigger mode, polarity and remote-acknowledge flag, and they change at the edge that updates the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Bus offset (0x00 selector, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_irr_set | input | 24 | Per-entry remote-acknowledge set pulse |
| hw_irr_clr | input | 24 | Per-entry remote-acknowledge clear pulse |
| hw_pend | input | 24 | Per-entry delivery-pending level |
| ent_mask | output | 24 | Per-entry mask bit |
| ent_level | output | 24 | Per-entry trigger mode (1 = level) |
| ent_polarity | output | 24 | Per-entry polarity |
| ent_irr | output | 24 | Per-entry remote-acknowledge flag |

## Verification
A read result appears on bus_rdata one clock edge after the cycle in which bus_rd is high. A write reaches the selector, the identification value, an entry and the per-entry outputs at the edge that samples bus_wr, and a hardware pulse reaches the status bits at the edge that samples it. The bench's driver queues the expected word when it raises bus_rd. A monitor records that a read strobe was seen at a rising edge and compares the popped word at the following falling edge. Direct checks on the per-entry outputs sample at the falling edge after the write or pulse has been clocked in.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    localparam logic [31:0] VERSION_WORD   = 32'h0017_0011;
    localparam logic [7:0]  SEL_ID         = 8'h00;
    localparam logic [7:0]  SEL_VER        = 8'h01;
    localparam logic [7:0]  SEL_ARB        = 8'h02;
    localparam logic [7:0]  SEL_TABLE_BASE = 8'h10;

    typedef enum logic [2:0] {
        ACC_ID,
        ACC_VER,
        ACC_ARB,
        ACC_HOLE,
        ACC_ENTRY,
        ACC_BAD
    } acc_kind_e;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       pol;
        logic       dst_mode;
        logic [2:0] dlv_mode;
        logic [7:0] vector;
    } ent_cfg_t;
endpackage

// File: rtl/irqr_decode.sv
module irqr_decode
    import irqr_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic [7:0]       sel,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    localparam logic [6:0] NUM_ENT_W = 7'(NUM_ENT);

    logic [7:0] off;
    logic [6:0] idx_full;

    always_comb begin
        off      = sel - SEL_TABLE_BASE;
        idx_full = off[7:1];
        idx      = idx_full[IDX_W-1:0];
        hi       = off[0];
        if (sel < SEL_TABLE_BASE) begin
            unique case (sel)
                SEL_ID:  kind = ACC_ID;
                SEL_VER: kind = ACC_VER;
                SEL_ARB: kind = ACC_ARB;
                default: kind = ACC_HOLE;
            endcase
        end else if (idx_full < NUM_ENT_W) begin
            kind = ACC_ENTRY;
        end else begin
            kind = ACC_BAD;
        end
    end
endmodule

// File: rtl/irqr_entry.sv
module irqr_entry
    import irqr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        hw_irr_set,
    input  logic        hw_irr_clr,
    input  logic        hw_pend,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word,
    output logic        mask_o,
    output logic        level_o,
    output logic        pol_o,
    output logic        irr_o
);
    ent_cfg_t cfg_q;
    logic     irr_q;
    logic     pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mask <= 1'b1;
        end else begin
            if (wr_lo) begin
                cfg_q.vector   <= wdata[7:0];
                cfg_q.dlv_mode <= wdata[10:8];
                cfg_q.dst_mode <= wdata[11];
                cfg_q.pol      <= wdata[13];
                cfg_q.level    <= wdata[15];
                cfg_q.mask     <= wdata[16];
            end
            if (wr_hi) begin
                cfg_q.dest <= wdata[31:24];
            end
        end
    end

    // Hardware-owned status: software cannot write these bits directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= hw_pend;
            if (wr_lo && !wdata[15]) begin
                irr_q <= 1'b0;
            end else if (hw_irr_set) begin
                irr_q <= 1'b1;
            end else if (hw_irr_clr) begin
                irr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        lo_word = {15'b0, cfg_q.mask, cfg_q.level, irr_q, cfg_q.pol, pend_q,
                   cfg_q.dst_mode, cfg_q.dlv_mode, cfg_q.vector};
        hi_word = {cfg_q.dest, 24'b0};
        mask_o  = cfg_q.mask;
        level_o = cfg_q.level;
        pol_o   = cfg_q.pol;
        irr_o   = irr_q;
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irqr_pkg::*;
#(
    parameter int         NUM_ENT  = 24,
    parameter logic [7:0] ADDR_SEL = 8'h00,
    parameter logic [7:0] ADDR_WIN = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_ENT-1:0] hw_irr_set,
    input  logic [NUM_ENT-1:0] hw_irr_clr,
    input  logic [NUM_ENT-1:0] hw_pend,
    output logic [NUM_ENT-1:0] ent_mask,
    output logic [NUM_ENT-1:0] ent_level,
    output logic [NUM_ENT-1:0] ent_polarity,
    output logic [NUM_ENT-1:0] ent_irr
);
    localparam int IDX_W = $clog2(NUM_ENT);

    logic [7:0]        sel_q;
    logic [3:0]        id_q;
    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              hi;
    logic              win_wr;
    logic [31:0]       rd_next;
    logic [31:0]       ent_word;
    logic [31:0]       lo_words [NUM_ENT];
    logic [31:0]       hi_words [NUM_ENT];

    irqr_decode #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_dec (
        .sel  (sel_q),
        .kind (kind),
        .idx  (idx),
        .hi   (hi)
    );

    assign win_wr = bus_wr && (bus_addr == ADDR_WIN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_SEL) begin
                sel_q <= bus_wdata[7:0];
            end
            if (win_wr && kind == ACC_ID) begin
                id_q <= bus_wdata[27:24];
            end
        end
    end

    for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
        logic hit;
        assign hit = win_wr && (kind == ACC_ENTRY) && (idx == IDX_W'(gi));
        irqr_entry u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (hit && !hi),
            .wr_hi      (hit && hi),
            .wdata      (bus_wdata),
            .hw_irr_set (hw_irr_set[gi]),
            .hw_irr_clr (hw_irr_clr[gi]),
            .hw_pend    (hw_pend[gi]),
            .lo_word    (lo_words[gi]),
            .hi_word    (hi_words[gi]),
            .mask_o     (ent_mask[gi]),
            .level_o    (ent_level[gi]),
            .pol_o      (ent_polarity[gi]),
            .irr_o      (ent_irr[gi])
        );
    end

    always_comb begin
        ent_word = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (idx == IDX_W'(i)) begin
                ent_word = hi ? hi_words[i] : lo_words[i];
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (bus_addr == ADDR_SEL) begin
            rd_next = {24'b0, sel_q};
        end else if (bus_addr == ADDR_WIN) begin
            unique case (kind)
                ACC_ID, ACC_ARB: rd_next = {4'b0, id_q, 24'b0};
                ACC_VER:         rd_next = VERSION_WORD;
                ACC_ENTRY:       rd_next = ent_word;
                ACC_BAD:         rd_next = '1;
                default:         rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker #(
    parameter int NUM_ENT = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [7:0]         sel_q,
    input logic [NUM_ENT-1:0] hw_irr_set,
    input logic [NUM_ENT-1:0] ent_irr
);
    localparam int BAD_START = 16 + 2 * NUM_ENT;

    p_version_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h10 && sel_q == 8'h01) |=> bus_rdata == 32'h0017_0011);

    p_arb_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h10 && sel_q == 8'h02) |=> (bus_rdata & 32'hF0FF_FFFF) == 32'h0);

    p_bad_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h10 && 32'(sel_q) >= 32'(BAD_START)) |=> bus_rdata == 32'hFFFF_FFFF);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_irr
        p_irr_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ent_irr[gi]) |-> $past(hw_irr_set[gi]));
    end
endmodule

bind irq_route_regs irqr_checker #(.NUM_ENT(NUM_ENT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .sel_q      (sel_q),
    .hw_irr_set (hw_irr_set),
    .ent_irr    (ent_irr)
);

// File: tb/irq_route_regs_tb.sv
module irq_route_regs_tb;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  hw_irr_set = '0;
    logic [N-1:0]  hw_irr_clr = '0;
    logic [N-1:0]  hw_pend = '0;
    logic [N-1:0]  ent_mask, ent_level, ent_polarity, ent_irr;

    int            n_tests = 0;
    int            n_fail  = 0;
    bit            done    = 1'b0;
    logic          rd_q    = 1'b0;
    logic [31:0]   exp_q [$];
    string         tag_q [$];

    always #4 clk = ~clk;

    irq_route_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_irr_set(hw_irr_set), .hw_irr_clr(hw_irr_clr), .hw_pend(hw_pend),
        .ent_mask(ent_mask), .ent_level(ent_level),
        .ent_polarity(ent_polarity), .ent_irr(ent_irr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: a read strobe seen at a rising edge is due on bus_rdata by the next falling edge.
    always @(posedge clk) rd_q <= bus_rd;
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R11: actual unexpected read 0x%08h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_win(input logic [7:0] s, input logic [31:0] exp, input string tag);
        wr(8'h00, {24'b0, s});
        rd(8'h10, exp, tag);
    endtask

    task automatic wr_win(input logic [7:0] s, input logic [31:0] d);
        wr(8'h00, {24'b0, s});
        wr(8'h10, d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 mask reset", 32'(ent_mask), 32'h00FF_FFFF);
        check("R9 irr reset", 32'(ent_irr), 32'h0);
        check("R9 rdata reset", bus_rdata, 32'h0);
        rd(8'h00, 32'h0, "R9 selector reset");
        rd_win(8'h10, 32'h0001_0000, "R9 entry0 low reset");
        rd_win(8'h11, 32'h0, "R9 entry0 high reset");
        rd_win(8'h00, 32'h0, "R9 id reset");

        // R1 selector readback
        wr(8'h00, 32'hFFFF_FFA5);
        rd(8'h00, 32'h0000_00A5, "R1 selector A5");
        wr(8'h00, 32'h0000_00FF);
        rd(8'h00, 32'h0000_00FF, "R1 selector FF");

        // R2 version
        wr_win(8'h01, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0017_0011, "R2 version after write");

        // R3 / R4 id and arbitration alias
        wr_win(8'h00, 32'h1F3E_5D7C);
        rd(8'h10, 32'h0F00_0000, "R3 id nibble");
        rd_win(8'h02, 32'h0F00_0000, "R4 arb mirrors id");
        wr(8'h10, 32'hE0C1_A283);
        rd(8'h10, 32'h0F00_0000, "R4 arb write ignored");
        rd_win(8'h00, 32'h0F00_0000, "R4 id unchanged by arb write");

        // R5 out-of-range selectors
        rd_win(8'h05, 32'h0, "R5 low hole");
        wr(8'h10, 32'h1234_5678);
        rd(8'h10, 32'h0, "R5 low hole after write");
        rd_win(8'h40, 32'hFFFF_FFFF, "R5 index 24");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'hFFFF_FFFF, "R5 index 24 after write");
        rd_win(8'hFF, 32'hFFFF_FFFF, "R5 selector FF");

        // R6 / R12 entry layout on the last entry (selectors 0x3E/0x3F)
        wr_win(8'h3E, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0001_AFFF, "R6 low all ones");
        check("R12 mask out", 32'(ent_mask[23]), 32'h1);
        check("R12 level out", 32'(ent_level[23]), 32'h1);
        check("R12 polarity out", 32'(ent_polarity[23]), 32'h1);
        wr_win(8'h3F, 32'hFFFF_FFFF);
        rd(8'h10, 32'hFF00_0000, "R6 high all ones");
        wr_win(8'h3E, 32'h0000_965F);
        rd(8'h10, 32'h0000_865F, "R6 low pattern");
        check("R12 mask cleared", 32'(ent_mask[23]), 32'h0);
        check("R12 polarity cleared", 32'(ent_polarity[23]), 32'h0);
        wr_win(8'h3F, 32'h3A00_0000);
        rd(8'h10, 32'h3A00_0000, "R6 high pattern");
        rd_win(8'h10, 32'h0001_0000, "R6 entry0 untouched");

        // R7 / R8 remote acknowledge on entry 5 (selector 0x1A)
        wr_win(8'h1A, 32'h0000_8020);
        @(negedge clk); hw_irr_set[5] = 1'b1;
        @(negedge clk); hw_irr_set[5] = 1'b0;
        check("R12 irr out set", 32'(ent_irr), 32'h0000_0020);
        rd(8'h10, 32'h0000_C020, "R7 irr set by hardware");
        wr(8'h10, 32'h0000_8021);
        rd(8'h10, 32'h0000_C021, "R7 irr write ignored");
        @(negedge clk); hw_irr_clr[5] = 1'b1;
        @(negedge clk); hw_irr_clr[5] = 1'b0;
        rd(8'h10, 32'h0000_8021, "R7 irr cleared by hardware");
        @(negedge clk); hw_irr_set[5] = 1'b1; hw_irr_clr[5] = 1'b1;
        @(negedge clk); hw_irr_set[5] = 1'b0; hw_irr_clr[5] = 1'b0;
        rd(8'h10, 32'h0000_C021, "R7 set wins over clear");
        wr(8'h10, 32'h0000_0021);
        check("R8 irr out cleared", 32'(ent_irr[5]), 32'h0);
        rd(8'h10, 32'h0000_0021, "R8 edge write clears irr");

        // R7 delivery pending on entry 3 (selector 0x16)
        @(negedge clk); hw_pend[3] = 1'b1;
        wr_win(8'h16, 32'h0000_0000);
        rd(8'h10, 32'h0000_1000, "R7 pending follows hardware");

        // R10 other offsets
        wr(8'h00, 32'h0000_0033);
        wr(8'h04, 32'h0000_0077);
        rd(8'h00, 32'h0000_0033, "R10 write elsewhere ignored");
        rd(8'h08, 32'h0, "R10 read elsewhere zero");

        // R11 hold between reads
        repeat (3) @(negedge clk);
        check("R11 rdata held", bus_rdata, 32'h0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule